// File: doc/BRIEF.md
# Real-Time Counter with Alarm

This block keeps elapsed time as one binary count that is 40 bits wide. The upper 32 bits count whole seconds. The lower 8 bits count 1/256 fractions of a second. The block is fed by a one-cycle `tick` strobe taken from a 32.768 kHz source. An internal prescaler turns every 128 accepted strobes into one fraction step. When the fraction field overflows, the seconds field advances by one.

A time-of-day alarm holds a 20-bit value. When the alarm is enabled and a seconds increment makes the low 20 second bits equal that value, a sticky flag is set. The flag drives `alarm_irq`. The alarm value and the alarm enable can only be changed while an unlock bit, set by an earlier write, is held.

A host uses one command channel and one response channel, both valid/ready. A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both high. A write has no response. A read returns exactly one response beat, and that beat is held until the host takes it. While a response waits with `rsp_ready` low, `cmd_ready` is low and no new command is taken. The command side therefore stalls; it never drops a command.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset the count, the control bits, the alarm value and the flag all read zero, `alarm_irq` is 0 and `rsp_valid` is 0.
- R2: The count rises by one in its lowest bit once every 128 `tick` strobes, counting only strobes that arrive while the run bit (address 0, bit 0) is 1. Strobes that arrive with run at 0 change nothing.
- R3: A fraction overflow (0xFF to 0x00) raises the seconds field by one. The seconds field wraps from all ones to zero, so the whole 40-bit count wraps to zero.
- R4: A write to address 1 loads all 40 bits as {seconds, fraction} and clears the prescaler. The next fraction step then needs a full 128 strobes. When a load and a step fall in the same cycle, the load wins.
- R5: A read of address 1 returns the 40-bit count as it stood in the cycle the read was accepted. The response data stays unchanged while it waits for `rsp_ready`.
- R6: A write to the alarm value (address 2) takes effect only if the unlock bit (address 0, bit 1) was already 1 before that write. The same rule applies to the alarm-enable bit (address 0, bit 2). A write to address 0 always updates the run and unlock bits.
- R7: If alarm-enable is 1 and a seconds increment makes seconds[19:0] equal the alarm value, the flag (address 3, bit 0) is set and `alarm_irq` goes high on the same clock edge. With alarm-enable at 0 the flag is never set.
- R8: A write to address 3 with bit 0 = 1 clears the flag. If a match sets the flag in that same cycle, the flag stays set.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `cmd_ready` is 0 and an offered command has no effect.
- R10: Read data is zero-extended to 40 bits. Address 0 returns {enable, unlock, run} in bits 2..0. Address 2 returns the 20-bit alarm value. Alarm writes keep only bits 19:0 of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe at 32.768 kHz |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 2 | Register address (0 ctrl, 1 count, 2 alarm, 3 status) |
| cmd_wdata | input | 40 | Write data |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 40 | Read response data |
| alarm_irq | output | 1 | Sticky alarm flag |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a host load of the count and a prescaler step. The bench runs the prescaler to 127 and then issues the load with `tick` high in the accept cycle. It expects the loaded value, followed by a full 128-strobe wait before the next step. The second pair is a flag-clear write and an alarm match. The bench times the clear to coincide with the matching seconds carry and expects the flag to survive. A read accepted together with a fraction step must return the value from before the step, and it must hold under back-pressure. A cycle-by-cycle reference model checks every edge as well.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_ALARM  = 2'd2,
    REG_STATUS = 2'd3
  } rtc_reg_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_UNL_BIT = 1;
  localparam int CTRL_AEN_BIT = 2;
  localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic clear,
  output logic step
);
  localparam int PW = (PRESC > 2) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_inc;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  generate
    if ((PRESC & (PRESC - 1)) == 0) begin : g_pow2
      assign cnt_inc = cnt_q + 1'b1;
    end else begin : g_mod
      assign cnt_inc = at_last ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= cnt_inc;
    end
  end

  assign step = run && tick && at_last && !clear;

  p_prescale_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_prescale_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt_q));
  p_prescale_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 8,
  parameter int ALM_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [SEC_W+SUB_W-1:0] load_val,
  input  logic                   step,
  output logic [SEC_W+SUB_W-1:0] count,
  output logic                   sec_tick,
  output logic [ALM_W-1:0]       sec_new_low
);
  localparam int CNT_W = SEC_W + SUB_W;

  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] sec_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sec_inc     = cnt_q[CNT_W-1:SUB_W] + 1'b1;
  assign sec_tick    = step && !load && (&cnt_q[SUB_W-1:0]);
  assign sec_new_low = sec_inc[ALM_W-1:0];
  assign count       = cnt_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(count));
  p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (&count[SUB_W-1:0])) |=>
      (count[SUB_W-1:0] == '0) &&
      (count[CNT_W-1:SUB_W] == $past(count[CNT_W-1:SUB_W]) + 1'b1));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int ALM_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unlock,
  input  logic             ctrl_wr,
  input  logic             aen_wdata,
  input  logic             alarm_wr,
  input  logic [ALM_W-1:0] alarm_wdata,
  input  logic             flag_clr,
  input  logic             sec_tick,
  input  logic [ALM_W-1:0] sec_new_low,
  output logic             aen,
  output logic [ALM_W-1:0] alarm_val,
  output logic             flag
);
  logic             aen_q;
  logic             flag_q;
  logic [ALM_W-1:0] alarm_q;
  logic             hit;

  assign hit = aen_q && sec_tick && (sec_new_low == alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aen_q   <= 1'b0;
      alarm_q <= '0;
    end else begin
      if (ctrl_wr && unlock) aen_q <= aen_wdata;
      if (alarm_wr && unlock) alarm_q <= alarm_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign aen       = aen_q;
  assign alarm_val = alarm_q;
  assign flag      = flag_q;

  p_alarm_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_wr && !unlock) |=> $stable(alarm_val));
  p_enable_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !unlock) |=> $stable(aen));
  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(aen && sec_tick));
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(aen && sec_tick && (sec_new_low == alarm_val))) |=> !flag);
endmodule

// File: rtl/rtc_hostport.sv
module rtc_hostport
  import rtc_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int ALM_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [1:0]       cmd_addr,
  input  logic [CNT_W-1:0] cmd_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_data,
  input  logic [CNT_W-1:0] count,
  input  logic [ALM_W-1:0] alarm_val,
  input  logic             aen,
  input  logic             flag,
  output logic             run,
  output logic             unlock,
  output logic             load,
  output logic             ctrl_wr,
  output logic             alarm_wr,
  output logic             flag_clr
);
  logic             rsp_valid_q;
  logic [CNT_W-1:0] rsp_data_q;
  logic             run_q;
  logic             unl_q;
  logic             acc;
  logic             wr_acc;
  logic             rd_acc;
  logic [CNT_W-1:0] rd_mux;

  assign cmd_ready = !rsp_valid_q || rsp_ready;
  assign acc       = cmd_valid && cmd_ready;
  assign wr_acc    = acc && cmd_write;
  assign rd_acc    = acc && !cmd_write;

  always_comb begin
    rd_mux = '0;
    case (cmd_addr)
      REG_CTRL: begin
        rd_mux[CTRL_RUN_BIT] = run_q;
        rd_mux[CTRL_UNL_BIT] = unl_q;
        rd_mux[CTRL_AEN_BIT] = aen;
      end
      REG_COUNT:  rd_mux = count;
      REG_ALARM:  rd_mux = CNT_W'(alarm_val);
      default:    rd_mux[STAT_FLAG_BIT] = flag;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_acc) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      unl_q <= 1'b0;
    end else if (wr_acc && (cmd_addr == REG_CTRL)) begin
      run_q <= cmd_wdata[CTRL_RUN_BIT];
      unl_q <= cmd_wdata[CTRL_UNL_BIT];
    end
  end

  assign load      = wr_acc && (cmd_addr == REG_COUNT);
  assign ctrl_wr   = wr_acc && (cmd_addr == REG_CTRL);
  assign alarm_wr  = wr_acc && (cmd_addr == REG_ALARM);
  assign flag_clr  = wr_acc && (cmd_addr == REG_STATUS) && cmd_wdata[STAT_FLAG_BIT];
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign run       = run_q;
  assign unlock    = unl_q;

  p_rsp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  p_stall_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> ($stable(run) && $stable(unlock)));
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 8,
  parameter int ALM_W = 20,
  parameter int PRESC = 128,
  localparam int CNT_W = SEC_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [1:0]       cmd_addr,
  input  logic [CNT_W-1:0] cmd_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_data,
  output logic             alarm_irq
);
  logic             run;
  logic             unlock;
  logic             load;
  logic             ctrl_wr;
  logic             alarm_wr;
  logic             flag_clr;
  logic             step;
  logic             sec_tick;
  logic [ALM_W-1:0] sec_new_low;
  logic [CNT_W-1:0] count;
  logic             aen;
  logic [ALM_W-1:0] alarm_val;
  logic             flag;

  rtc_hostport #(.CNT_W(CNT_W), .ALM_W(ALM_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .count(count), .alarm_val(alarm_val), .aen(aen), .flag(flag),
    .run(run), .unlock(unlock), .load(load), .ctrl_wr(ctrl_wr),
    .alarm_wr(alarm_wr), .flag_clr(flag_clr)
  );

  rtc_prescaler #(.PRESC(PRESC)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .clear(load), .step(step)
  );

  rtc_counter #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ALM_W(ALM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cmd_wdata),
    .step(step), .count(count), .sec_tick(sec_tick),
    .sec_new_low(sec_new_low)
  );

  rtc_alarm #(.ALM_W(ALM_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .unlock(unlock),
    .ctrl_wr(ctrl_wr), .aen_wdata(cmd_wdata[rtc_pkg::CTRL_AEN_BIT]),
    .alarm_wr(alarm_wr), .alarm_wdata(cmd_wdata[ALM_W-1:0]),
    .flag_clr(flag_clr), .sec_tick(sec_tick), .sec_new_low(sec_new_low),
    .aen(aen), .alarm_val(alarm_val), .flag(flag)
  );

  assign alarm_irq = flag;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!alarm_irq && !rsp_valid));
endmodule

// File: tb/rtc_alarm_core_bench.sv
module rtc_alarm_core_bench;
  localparam int CW = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_write = 1'b0;
  logic [1:0]    cmd_addr = 2'd0;
  logic [CW-1:0] cmd_wdata = '0;
  logic          rsp_ready = 1'b1;
  logic          cmd_ready;
  logic          rsp_valid;
  logic [CW-1:0] rsp_data;
  logic          alarm_irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  rtc_alarm_core u_rtc_alarm_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .alarm_irq(alarm_irq)
  );

  // behavioural reference
  logic [CW-1:0] m_cnt;
  int            m_pre;
  logic          m_run, m_unl, m_aen, m_flag, m_rsp_valid;
  logic [19:0]   m_alarm;
  logic [CW-1:0] m_rsp_data;

  function automatic logic [CW-1:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return CW'({m_aen, m_unl, m_run});
      2'd1: return m_cnt;
      2'd2: return CW'(m_alarm);
      default: return CW'(m_flag);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_pre = 0; m_run = 0; m_unl = 0; m_aen = 0;
      m_flag = 0; m_rsp_valid = 0; m_alarm = '0; m_rsp_data = '0;
    end else begin
      logic acc, old_unl, old_aen, set_f;
      logic [31:0] nsec;
      acc = cmd_valid && (!m_rsp_valid || rsp_ready);
      old_unl = m_unl; old_aen = m_aen; set_f = 0;
      if (acc && !cmd_write) begin
        m_rsp_data = m_read(cmd_addr); m_rsp_valid = 1;
      end else if (rsp_ready) m_rsp_valid = 0;
      if (acc && cmd_write && cmd_addr == 2'd1) begin
        m_cnt = cmd_wdata; m_pre = 0;
      end else if (m_run && tick) begin
        if (m_pre == 127) begin
          m_pre = 0;
          nsec = m_cnt[39:8] + 1;
          if (m_cnt[7:0] == 8'hFF && old_aen && nsec[19:0] == m_alarm) set_f = 1;
          m_cnt = m_cnt + 1;
        end else m_pre++;
      end
      if (acc && cmd_write) begin
        case (cmd_addr)
          2'd0: begin m_run = cmd_wdata[0]; m_unl = cmd_wdata[1];
                  if (old_unl) m_aen = cmd_wdata[2]; end
          2'd2: if (old_unl) m_alarm = cmd_wdata[19:0];
          2'd3: if (cmd_wdata[0]) m_flag = 0;
          default: ;
        endcase
      end
      if (set_f) m_flag = 1;
    end
  end

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #2;
      chk("R7 irq vs model", CW'(alarm_irq), CW'(m_flag));
      chk("R5 rsp_valid vs model", CW'(rsp_valid), CW'(m_rsp_valid));
      chk("R9 cmd_ready vs model", CW'(cmd_ready), CW'(!m_rsp_valid || rsp_ready));
      if (m_rsp_valid) chk("R5 rsp_data vs model", rsp_data, m_rsp_data);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d, input logic tk = 1'b0);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d; tick = tk;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0; tick = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    d = rsp_data;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic expect_reg(input string tag, input logic [1:0] a, input logic [CW-1:0] exp);
    logic [CW-1:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq after reset", CW'(alarm_irq), '0);
    rst_n = 1;
    chk("R1 rsp_valid after reset", CW'(rsp_valid), '0);
    expect_reg("R1 count reset", 2'd1, '0);
    expect_reg("R1 ctrl reset", 2'd0, '0);
    expect_reg("R1 alarm reset", 2'd2, '0);
    expect_reg("R1 flag reset", 2'd3, '0);

    // R2 prescaling and run gating
    wr(2'd0, 40'h1);
    pulse(127);
    expect_reg("R2 no step after 127", 2'd1, 40'h0);
    pulse(1);
    expect_reg("R2 step at 128", 2'd1, 40'h1);
    wr(2'd0, 40'h0);
    pulse(300);
    expect_reg("R2 stopped ignores ticks", 2'd1, 40'h1);
    wr(2'd0, 40'h1);

    // R4 load clears prescaler
    pulse(60);
    wr(2'd1, 40'h00_0123_4510);
    pulse(127);
    expect_reg("R4 full period after load", 2'd1, 40'h00_0123_4510);
    pulse(1);
    expect_reg("R4 step after load", 2'd1, 40'h00_0123_4511);
    pulse(127);
    wr(2'd1, 40'h00_0000_0A00, 1'b1);
    expect_reg("R4 load beats step", 2'd1, 40'h00_0000_0A00);
    pulse(127);
    expect_reg("R4 prescaler restarted", 2'd1, 40'h00_0000_0A00);
    pulse(1);
    expect_reg("R4 step after coincident load", 2'd1, 40'h00_0000_0A01);

    // R3 carry and wrap
    wr(2'd1, 40'h00_0000_07FF);
    pulse(128);
    expect_reg("R3 fraction carry", 2'd1, 40'h00_0000_0800);
    wr(2'd1, 40'hFF_FFFF_FFFF);
    pulse(128);
    expect_reg("R3 full wrap", 2'd1, 40'h0);

    // R6 write guard, R10 layout
    wr(2'd2, 40'h5);
    expect_reg("R6 alarm locked", 2'd2, 40'h0);
    wr(2'd0, 40'h5);
    expect_reg("R6 enable locked", 2'd0, 40'h1);
    wr(2'd0, 40'h3);
    expect_reg("R6 unlock same write no enable", 2'd0, 40'h3);
    wr(2'd0, 40'h7);
    expect_reg("R10 ctrl layout", 2'd0, 40'h7);
    wr(2'd2, 40'hFF_FFF0_0005);
    expect_reg("R10 alarm truncated", 2'd2, 40'h5);

    // R7 match
    wr(2'd1, 40'h00_0000_04FE);
    pulse(128);
    expect_reg("R7 no flag before match", 2'd3, 40'h0);
    pulse(128);
    expect_reg("R7 flag on match", 2'd3, 40'h1);
    chk("R7 irq high", CW'(alarm_irq), 40'h1);

    // R8 clear and collision
    wr(2'd3, 40'h1);
    expect_reg("R8 cleared", 2'd3, 40'h0);
    wr(2'd1, 40'h00_0000_04FF);
    pulse(127);
    wr(2'd3, 40'h1, 1'b1);
    expect_reg("R8 set wins over clear", 2'd3, 40'h1);
    expect_reg("R8 count advanced", 2'd1, 40'h00_0000_0500);
    wr(2'd3, 40'h1);
    wr(2'd0, 40'h3);
    wr(2'd1, 40'h00_0000_04FF);
    pulse(128);
    expect_reg("R7 disabled no flag", 2'd3, 40'h0);

    // R5 snapshot with back-pressure, R9 stall
    wr(2'd1, 40'h00_0000_0920);
    pulse(127);
    @(negedge clk);
    rsp_ready = 0; cmd_valid = 1; cmd_write = 0; cmd_addr = 2'd1; tick = 1;
    @(negedge clk);
    tick = 0; cmd_write = 1; cmd_addr = 2'd0; cmd_wdata = 40'h0;
    for (int i = 0; i < 4; i++) begin
      chk("R5 held snapshot", rsp_data, 40'h00_0000_0920);
      chk("R9 ready low while stalled", CW'(cmd_ready), '0);
      @(negedge clk);
    end
    cmd_valid = 0;
    rsp_ready = 1;
    expect_reg("R9 stalled write dropped", 2'd0, 40'h3);
    expect_reg("R5 count moved on", 2'd1, 40'h00_0000_0921);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule